// File: doc/BRIEF.md
# Peak-Clamped Discontinuous PWM Gate Generator

This block drives the six gates of a two-level, three-phase inverter bridge. Once per carrier period it takes three signed phase reference samples, finds their largest and smallest values, and adds one common-mode offset to all three. In discontinuous mode the offset pushes the phase with the largest magnitude to full scale of its own sign. That phase is then held at the positive or negative rail for the 60° window around its voltage peak. The clamped phase changes every 60° of the fundamental, and the clamp polarity alternates with it. In continuous mode the offset centres the three references between the rails, which gives space-vector modulation.

The adjusted references are compared with a symmetric up/down carrier counter. New references are taken only at the carrier valley, so a pulse never changes inside a period. The compare result is the ideal switch state of each leg. Each leg then drives its high-side and low-side gates as complements, with a programmable dead gap on every change. The low side therefore conducts as a synchronous rectifier whenever the high side is off.

Top module: `dpwm_gate_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all six gates, `state_code` and `period_start` are 0. The gates stay low until the first set of references has been taken at a carrier valley.
- R2: The carrier counts 0,1,…,T,T−1,…,0 with T = `carrier_top` (T ≥ 2), so one period is 2·T clocks. `period_start` is high for exactly one clock per period: the first clock in which newly taken references apply. It is first high in the second clock after reset is released.
- R3: References are sampled only in the last clock of a period (counter at 0). A change of `ref_a`/`ref_b`/`ref_c` in the middle of a period has no effect on that period's outputs.
- R4: In discontinuous mode (`svm_mode`=0), with mx/mn the largest and smallest of the three references and FS = 2^(REF_W−1)−1, the offset is FS−mx when |mx| ≥ |mn| and −FS−mn otherwise.
- R5: In space-vector mode (`svm_mode`=1) the offset is floor(−(mx+mn)/2).
- R6: Each adjusted reference v = ref+offset is limited to ±FS. A phase with v = FS is high for the whole period, and a phase with v = −FS is low for the whole period. Otherwise, with h = floor((v+FS)·(T+1)/2^REF_W), the phase is high for 0 clocks when h = 0 and for 2h−1 clocks of the period otherwise.
- R7: In discontinuous mode, with three balanced references and no tie in magnitude, exactly one phase is held constant for the whole period. It is held high if its reference is positive and low if it is negative. Each time the held phase changes along a rising angle, the polarity flips.
- R8: `state_code` gives the ideal switch states: bit 2 is phase A, bit 1 is phase B, bit 0 is phase C, and 1 means the high side is on. All-zero references in discontinuous mode give the zero vector 111.
- R9: Each change of a leg's ideal state is followed by D+1 clocks with both of its gates low, where D = `dead_cnt`. Outside these gaps the low-side gate is the complement of the high-side gate. For a steady waveform with a high run of H clocks per period, the high gate is on for H−(D+1) clocks and the low gate for 2T−H−(D+1) clocks, provided each run is at least D+2 clocks long.
- R10: The high-side and low-side gates of a leg are never on together.
- R11: Over a full fundamental cycle at the same carrier, each leg makes two thirds as many state changes in discontinuous mode as in space-vector mode.
- R12: In space-vector mode, references within the linear range never clamp a phase: every phase changes state in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| svm_mode | input | 1 | 1 selects continuous space-vector offset, 0 selects peak-clamped offset |
| carrier_top | input | CNT_W | Carrier peak count T; the period is 2·T clocks |
| dead_cnt | input | DT_W | Dead gap length D; both gates are low for D+1 clocks per change |
| ref_a | input | REF_W | Phase A reference, signed |
| ref_b | input | REF_W | Phase B reference, signed |
| ref_c | input | REF_W | Phase C reference, signed |
| gate_hi | output | 3 | High-side gates, bit 2 = A, bit 0 = C |
| gate_lo | output | 3 | Low-side gates, bit 2 = A, bit 0 = C |
| state_code | output | 3 | Ideal switch state vector, bit 2 = A |
| period_start | output | 1 | One-clock marker of the first clock of each carrier period |

## Verification
The properties assume that `carrier_top` is at least 2 and that both `carrier_top` and `dead_cnt` stay fixed while the block runs. They also assume that the references stay within ±FS. The stimulus sets both settings once before reset is released. It draws balanced sinusoidal references of 0.9 full-scale amplitude, with angles chosen so that no two phases tie in magnitude. It adds a few directed vectors inside the same range. The gate-width checks are applied only to periods that repeat the waveform of the period before, and only when every high or low run is longer than the dead gap.

// File: rtl/dpwm_gate_gen.sv
module dpwm_gate_gen #(
  parameter int REF_W = 12,
  parameter int CNT_W = 10,
  parameter int DT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    svm_mode,
  input  logic [CNT_W-1:0]        carrier_top,
  input  logic [DT_W-1:0]         dead_cnt,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  output logic [2:0]              gate_hi,
  output logic [2:0]              gate_lo,
  output logic [2:0]              state_code,
  output logic                    period_start
);
  localparam int XW = REF_W + 3;
  localparam int PW = REF_W + CNT_W + 2;
  localparam logic signed [XW-1:0] FS = XW'((1 << (REF_W - 1)) - 1);

  logic signed [XW-1:0] r [3];
  logic signed [XW-1:0] hi_ref, lo_ref, mag_hi, mag_lo, sum, off;
  logic signed [XW-1:0] adj_d [3];
  logic signed [XW-1:0] adj_q [3];
  logic [CNT_W-1:0]     cnt;
  logic                 up, armed;
  logic [REF_W:0]       span [3];
  logic [PW-1:0]        prod [3];
  logic [CNT_W+1:0]     thr  [3];
  logic [2:0]           ideal, prev_q, flip;
  logic [DT_W-1:0]      dtc [3];

  assign r[2] = XW'(ref_a);
  assign r[1] = XW'(ref_b);
  assign r[0] = XW'(ref_c);

  always_comb begin
    hi_ref = r[0];
    lo_ref = r[0];
    for (int i = 1; i < 3; i++) begin
      if (r[i] > hi_ref) hi_ref = r[i];
      if (r[i] < lo_ref) lo_ref = r[i];
    end
  end

  assign mag_hi = (hi_ref < 0) ? -hi_ref : hi_ref;
  assign mag_lo = (lo_ref < 0) ? -lo_ref : lo_ref;
  assign sum    = hi_ref + lo_ref;
  assign off    = svm_mode ? ((-sum) >>> 1)
                : (mag_hi >= mag_lo) ? (FS - hi_ref) : (-FS - lo_ref);

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (r[i] + off > FS)       adj_d[i] = FS;
      else if (r[i] + off < -FS) adj_d[i] = -FS;
      else                       adj_d[i] = r[i] + off;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      up    <= 1'b1;
      armed <= 1'b0;
      for (int i = 0; i < 3; i++) adj_q[i] <= '0;
    end else begin
      if (up) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt + CNT_W'(1) == carrier_top) up <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) up <= 1'b1;
      end
      if (cnt == '0) begin
        armed <= 1'b1;
        for (int i = 0; i < 3; i++) adj_q[i] <= adj_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      span[i]  = (REF_W+1)'(adj_q[i] + FS);
      prod[i]  = PW'(span[i]) * PW'(carrier_top) + PW'(span[i]);
      thr[i]   = (CNT_W+2)'(prod[i] >> REF_W);
      ideal[i] = armed & ((adj_q[i] >= FS) |
                 ((adj_q[i] > -FS) & ({2'b00, cnt} < thr[i])));
    end
  end

  assign state_code   = ideal;
  assign period_start = armed & up & (cnt == CNT_W'(1));
  assign flip         = ideal ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      gate_hi <= '0;
      gate_lo <= '0;
      for (int i = 0; i < 3; i++) dtc[i] <= '0;
    end else begin
      prev_q <= ideal;
      for (int i = 0; i < 3; i++) begin
        if (flip[i])            dtc[i] <= dead_cnt;
        else if (dtc[i] != '0)  dtc[i] <= dtc[i] - DT_W'(1);
        gate_hi[i] <= ideal[i] & ~flip[i] & (dtc[i] == '0);
        gate_lo[i] <= armed & ~ideal[i] & ~flip[i] & (dtc[i] == '0);
      end
    end
  end
endmodule

// File: rtl/dpwm_gate_gen_chk.sv
module dpwm_gate_gen_chk #(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              gate_hi,
  input logic [2:0]              gate_lo,
  input logic                    period_start,
  input logic [CNT_W-1:0]        cnt,
  input logic signed [REF_W+2:0] adj_a,
  input logic signed [REF_W+2:0] adj_b,
  input logic signed [REF_W+2:0] adj_c
);
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  a_r3_hold_a: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(adj_a));
  a_r3_hold_b: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(adj_b));
  a_r3_hold_c: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(adj_c));

  for (genvar g = 0; g < 3; g++) begin : g_leg
    a_r9_hi_after_gap: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[g]) |-> $past(!gate_lo[g]));
    a_r9_lo_after_gap: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[g]) |-> $past(!gate_hi[g]));
  end
endmodule

bind dpwm_gate_gen dpwm_gate_gen_chk #(.REF_W(REF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .period_start(period_start), .cnt(cnt),
  .adj_a(adj_q[2]), .adj_b(adj_q[1]), .adj_c(adj_q[0])
);

// File: tb/dpwm_gate_gen_bench.sv
module dpwm_gate_gen_bench;
  localparam int TOP = 200;
  localparam int DT  = 12;
  localparam int FS  = 2047;

  logic clk = 1'b0, rst = 1'b1, svm = 1'b0;
  logic signed [11:0] ra = '0, rb = '0, rc = '0;
  logic [2:0] gh, gl, code;
  logic pstart;

  always #10 clk = ~clk;

  dpwm_gate_gen u_dpwm_gate_gen (
    .clk(clk), .rst(rst), .svm_mode(svm), .carrier_top(10'(TOP)),
    .dead_cnt(8'(DT)), .ref_a(ra), .ref_b(rb), .ref_c(rc),
    .gate_hi(gh), .gate_lo(gl), .state_code(code), .period_start(pstart)
  );

  typedef struct {
    int a, b, c;
    bit svm, steady, sweep;
    int due;
    bit [2:0] mask, val;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, pidx = 0;
  int dp_tr[3], sv_tr[3];
  int la = 99999, lb = 0, lc = 0;
  bit lsvm = 0;

  always @(posedge clk) if (rst) pidx <= 0; else if (pstart) pidx <= pidx + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int adj_of(input int r, input int a, input int b, input int c, input bit s);
    int mx, mn, off, v;
    mx = a; mn = a;
    if (b > mx) mx = b; if (c > mx) mx = c;
    if (b < mn) mn = b; if (c < mn) mn = c;
    if (s) off = (-(mx + mn)) >>> 1;
    else off = (((mx < 0) ? -mx : mx) >= ((mn < 0) ? -mn : mn)) ? FS - mx : -FS - mn;
    v = r + off;
    if (v > FS) v = FS;
    if (v < -FS) v = -FS;
    return v;
  endfunction

  function automatic int exp_high(input int v);
    int h;
    if (v >= FS) return 2 * TOP;
    if (v <= -FS) return 0;
    h = ((v + FS) * (TOP + 1)) / 4096;
    return (h == 0) ? 0 : 2 * h - 1;
  endfunction

  task automatic drive(input int a, input int b, input int c, input bit s,
                       input bit sw, input bit [2:0] mask, input bit [2:0] val);
    item_t it;
    int n;
    do @(negedge clk); while (!pstart);
    n = pidx;
    repeat (TOP) @(negedge clk);
    ra = 12'(a); rb = 12'(b); rc = 12'(c); svm = s;
    it.a = a; it.b = b; it.c = c; it.svm = s; it.sweep = sw;
    it.steady = (a == la && b == lb && c == lc && s == lsvm);
    it.due = n + 1; it.mask = mask; it.val = val;
    q.push_back(it);
    la = a; lb = b; lc = c; lsvm = s;
  endtask

  // monitor: pops the item due in this period and scores it
  initial begin : monitor
    item_t it;
    int hc[3], ghc[3], glc[3], tr[3], refs[3], v, e, nclamp, cph, cpol, big;
    int last_ph, last_pol;
    bit [2:0] first, last;
    bit code_ok, overlap, early;
    last_ph = -1; last_pol = 0;
    forever begin
      @(negedge clk);
      if (!rst && pstart && q.size() > 0 && q[0].due == pidx) begin
        it = q.pop_front();
        for (int i = 0; i < 3; i++) begin hc[i] = 0; ghc[i] = 0; glc[i] = 0; tr[i] = 0; end
        code_ok = 1; overlap = 0; early = 0; first = code; last = code;
        for (int s = 0; s < 2 * TOP; s++) begin
          if (s > 0) begin
            @(negedge clk);
            if (pstart) early = 1;
          end
          for (int i = 0; i < 3; i++) begin
            hc[i] += code[i]; ghc[i] += gh[i]; glc[i] += gl[i];
            if (s > 0 && code[i] != last[i]) tr[i]++;
          end
          if ((gh & gl) != 3'b000) overlap = 1;
          if ((code & it.mask) != it.val) code_ok = 0;
          last = code;
        end
        for (int i = 0; i < 3; i++) if (first[i] != last[i]) tr[i]++;
        refs[2] = it.a; refs[1] = it.b; refs[0] = it.c;
        chk(!early, "R2 start marker inside period", int'(early), 0);
        chk(!overlap, "R10 both gates on", int'(overlap), 0);
        if (it.mask != 3'b000) chk(code_ok, "R8 state code bits", int'(code_ok), 1);
        nclamp = 0; cph = -1; cpol = 0;
        for (int i = 0; i < 3; i++) begin
          v = adj_of(refs[i], it.a, it.b, it.c, it.svm);
          e = exp_high(v);
          chk(hc[i] == e, it.svm ? "R6/R5 (R3) high cycles" : "R6/R4 (R3) high cycles", hc[i], e);
          if (hc[i] == 0 || hc[i] == 2 * TOP) begin
            nclamp++; cph = i; cpol = (hc[i] != 0) ? 1 : -1;
          end
          if (it.steady && (hc[i] == 0 || hc[i] == 2 * TOP ||
              (hc[i] >= DT + 2 && hc[i] <= 2 * TOP - DT - 2))) begin
            chk(ghc[i] == ((hc[i] == 0) ? 0 : (hc[i] == 2 * TOP) ? 2 * TOP : hc[i] - (DT + 1)),
                "R9 high gate cycles", ghc[i],
                (hc[i] == 0) ? 0 : (hc[i] == 2 * TOP) ? 2 * TOP : hc[i] - (DT + 1));
            chk(glc[i] == ((hc[i] == 0) ? 2 * TOP : (hc[i] == 2 * TOP) ? 0 : 2 * TOP - hc[i] - (DT + 1)),
                "R9 low gate cycles", glc[i],
                (hc[i] == 0) ? 2 * TOP : (hc[i] == 2 * TOP) ? 0 : 2 * TOP - hc[i] - (DT + 1));
          end
          if (it.sweep) begin
            if (it.svm) sv_tr[i] += tr[i]; else dp_tr[i] += tr[i];
          end
        end
        if (it.sweep && it.svm) chk(nclamp == 0, "R12 clamped phases in linear range", nclamp, 0);
        if (it.sweep && !it.svm) begin
          chk(nclamp == 1, "R7 clamped phase count", nclamp, 1);
          big = 0;
          for (int i = 1; i < 3; i++)
            if (((refs[i] < 0) ? -refs[i] : refs[i]) > ((refs[big] < 0) ? -refs[big] : refs[big])) big = i;
          chk(cph == big, "R7 clamped phase is largest magnitude", cph, big);
          chk(cpol == ((refs[big] > 0) ? 1 : -1), "R7 clamp polarity", cpol, (refs[big] > 0) ? 1 : -1);
          if (last_ph >= 0 && cph != last_ph)
            chk(cpol == -last_pol, "R7 polarity alternates", cpol, -last_pol);
          last_ph = cph; last_pol = cpol;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    real amp, th;
    int a, b, c;
    for (int i = 0; i < 3; i++) begin dp_tr[i] = 0; sv_tr[i] = 0; end
    repeat (4) @(negedge clk);
    chk(gh == 3'b000 && gl == 3'b000, "R1 gates in reset", int'({gh, gl}), 0);
    chk(code == 3'b000 && !pstart, "R1 code and marker in reset", int'({code, pstart}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pstart == 1'b1, "R2 first marker after release", int'(pstart), 1);
    chk(gh == 3'b000 && gl == 3'b000, "R1 gates before first valley", int'({gh, gl}), 0);

    repeat (2) drive(0, 0, 0, 1'b0, 1'b0, 3'b111, 3'b111);
    repeat (2) drive(1500, -200, -1300, 1'b0, 1'b0, 3'b100, 3'b100);
    repeat (2) drive(-1500, 200, 1300, 1'b0, 1'b0, 3'b100, 3'b000);
    repeat (2) drive(0, 0, 0, 1'b1, 1'b0, 3'b000, 3'b000);
    repeat (2) drive(1000, -300, -700, 1'b1, 1'b0, 3'b000, 3'b000);

    amp = 0.9 * FS;
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 24; k++) begin
        th = (7.5 + 15.0 * k) * 3.14159265358979 / 180.0;
        a = int'(amp * $cos(th));
        b = int'(amp * $cos(th - 2.0943951023932));
        c = int'(amp * $cos(th + 2.0943951023932));
        repeat (2) drive(a, b, c, bit'(m), 1'b1, 3'b000, 3'b000);
      end
    end

    wait (q.size() == 0);
    repeat (2 * TOP + 4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(sv_tr[i] > 0 && dp_tr[i] * 3 == sv_tr[i] * 2,
          "R11 discontinuous vs continuous changes x3", dp_tr[i] * 3, sv_tr[i] * 2);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule